// File: doc/BRIEF.md
# Two-Port Hardware Token Semaphore

This block holds a small bank of ownership tokens shared by two processor ports, called left and right. Software on each side uses a token to stake a claim on a region of a shared memory, so the memory itself needs no address-level arbitration. The tokens are separate from the memory contents. Each port has its own token-bank select, which is distinct from any memory chip select.

A port asks for a token by writing 0 to it. It then reads the token back. A 0 read tells the port that it owns the token. A port that reads 1 keeps polling until the read returns 0, which shows the other side has let the region go. If a port asks while the other side holds the token, its request is remembered. Ownership moves to it one clock after the holder writes 1. A simultaneous claim of a free token is resolved deterministically, in favour of the left port by default.

The whole bank runs on one clock. Writes take effect at the clock edge. Reads are combinational from the registered token state.

Top module: `sem_token_bank`

## Requirements
- R1: After reset every token is free, and a selected read (select=1, write strobe=0) of any index returns 1 on both ports.
- R2: A write of data 0 with select=1 to a free token makes the writing port its holder, and from the next cycle that port reads the token as 0.
- R3: A port that does not hold a token reads it as 1 while the other port holds it.
- R4: A write of 0 by one port to a token held by the other port leaves the holder unchanged and records the writer as waiting.
- R5: When the holder writes 1 and the other port is waiting, or writes 0 in that same cycle, the other port holds the token from the next cycle.
- R6: When the holder writes 1 and the other port is not waiting, the token is free from the next cycle.
- R7: When both ports write 0 to the same free token in the same cycle, the left port (with default parameter LEFT_WINS_TIE=1) becomes the holder and the right port is recorded as waiting.
- R8: A write of 1 by a port that neither holds nor waits for a token leaves the token's holder and waiting state unchanged.
- R9: A write of 1 by the waiting port withdraws its wait, so that a later release by the holder frees the token.
- R10: With select=0 a port's writes have no effect, and its read data is 1.
- R11: The token index (3 bits at default, token 0 to 7) picks exactly one token, and the tokens change state independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sem_sel | input | 1 | Left port token-bank select |
| l_idx | input | IDX_W | Left port token index |
| l_wr | input | 1 | Left port write strobe |
| l_wdata | input | 1 | Left port write bit (0 = claim, 1 = release) |
| l_rdata | output | 1 | Left port read bit (0 = left holds the token) |
| r_sem_sel | input | 1 | Right port token-bank select |
| r_idx | input | IDX_W | Right port token index |
| r_wr | input | 1 | Right port write strobe |
| r_wdata | input | 1 | Right port write bit (0 = claim, 1 = release) |
| r_rdata | output | 1 | Right port read bit (0 = right holds the token) |

## Verification
The assertions in each token cell check the state transitions on every cycle:
- the tie-break on a free token;
- the handoff to a waiting port;
- the release to free;
- that a holder keeps the token while it does not release it;
- that the waiting flag never names the holder;
- that an idle free token stays free.

Other behaviours are visible only in the bench's scenarios, because they depend on how the decoder and the read multiplexer connect to the cells:
- that the correct token is addressed and its neighbours are left alone;
- that an unselected port is ignored and reads 1;
- that the read-back returns 0 only to the holder;
- that polling finally succeeds.

// File: rtl/sem_pkg.sv
package sem_pkg;
   typedef enum logic [1:0] {
      TOK_FREE   = 2'd0,
      TOK_LEFT   = 2'd1,
      TOK_RIGHT  = 2'd2
   } tok_owner_t;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
   parameter int N_TOKENS = 8,
   localparam int IDX_W = (N_TOKENS > 1) ? $clog2(N_TOKENS) : 1
) (
   input  logic                sel,
   input  logic [IDX_W-1:0]    idx,
   input  logic                wr,
   input  logic                wdata,
   output logic [N_TOKENS-1:0] claim,
   output logic [N_TOKENS-1:0] drop
);
   logic active;
   assign active = sel & wr;

   for (genvar g = 0; g < N_TOKENS; g++) begin : g_dec
      logic hit;
      assign hit      = active && (idx == IDX_W'(g));
      assign claim[g] = hit & ~wdata;
      assign drop[g]  = hit &  wdata;
   end
endmodule

// File: rtl/sem_read_mux.sv
module sem_read_mux #(
   parameter int N_TOKENS = 8,
   localparam int IDX_W = (N_TOKENS > 1) ? $clog2(N_TOKENS) : 1
) (
   input  logic                sel,
   input  logic [IDX_W-1:0]    idx,
   input  logic [N_TOKENS-1:0] held,
   output logic                rdata
);
   logic in_range;
   assign in_range = (32'(idx) < N_TOKENS);

   always_comb begin
      rdata = 1'b1;
      if (sel && in_range) rdata = ~held[idx];
   end
endmodule

// File: rtl/sem_token_cell.sv
module sem_token_cell
   import sem_pkg::*;
#(
   parameter bit LEFT_WINS_TIE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic l_claim,
   input  logic l_drop,
   input  logic r_claim,
   input  logic r_drop,
   output logic l_held,
   output logic r_held
);
   tok_owner_t own_q, own_d;
   logic       wait_q, wait_d;   // the non-holding side is waiting
   logic       l_waits, r_waits;

   assign l_waits = (wait_q & ~l_drop) | l_claim;
   assign r_waits = (wait_q & ~r_drop) | r_claim;

   always_comb begin
      own_d  = own_q;
      wait_d = wait_q;
      unique case (own_q)
         TOK_FREE: begin
            wait_d = 1'b0;
            if (l_claim && r_claim) begin
               own_d  = LEFT_WINS_TIE ? TOK_LEFT : TOK_RIGHT;
               wait_d = 1'b1;
            end else if (l_claim) begin
               own_d = TOK_LEFT;
            end else if (r_claim) begin
               own_d = TOK_RIGHT;
            end
         end
         TOK_LEFT: begin
            if (l_drop) begin
               own_d  = r_waits ? TOK_RIGHT : TOK_FREE;
               wait_d = 1'b0;
            end else begin
               wait_d = r_waits;
            end
         end
         TOK_RIGHT: begin
            if (r_drop) begin
               own_d  = l_waits ? TOK_LEFT : TOK_FREE;
               wait_d = 1'b0;
            end else begin
               wait_d = l_waits;
            end
         end
         default: begin
            own_d  = TOK_FREE;
            wait_d = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_q  <= TOK_FREE;
         wait_q <= 1'b0;
      end else begin
         own_q  <= own_d;
         wait_q <= wait_d;
      end
   end

   assign l_held = (own_q == TOK_LEFT);
   assign r_held = (own_q == TOK_RIGHT);

   AST_TIE_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == TOK_FREE && l_claim && r_claim) |=>
         (l_held == LEFT_WINS_TIE && r_held == !LEFT_WINS_TIE && wait_q)); // R7
   AST_HANDOFF_R: assert property (@(posedge clk) disable iff (!rst_n)
      (l_held && l_drop && ((wait_q && !r_drop) || r_claim)) |=> r_held); // R5
   AST_HANDOFF_L: assert property (@(posedge clk) disable iff (!rst_n)
      (r_held && r_drop && ((wait_q && !l_drop) || l_claim)) |=> l_held); // R5
   AST_FREE_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (l_held && l_drop && !wait_q && !r_claim) |=> (!l_held && !r_held)); // R6
   AST_HOLDER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (l_held && !l_drop) |=> l_held); // R4
   AST_HOLDER_KEEPS_R: assert property (@(posedge clk) disable iff (!rst_n)
      (r_held && !r_drop) |=> r_held); // R4
   AST_IDLE_STAYS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_held && !r_held && !l_claim && !r_claim) |=> (!l_held && !r_held)); // R8
   AST_ONE_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({l_held, r_held})); // R3
   AST_WAIT_NEEDS_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
      wait_q |-> (l_held || r_held)); // R9
endmodule

// File: rtl/sem_token_bank.sv
module sem_token_bank #(
   parameter int N_TOKENS      = 8,
   parameter bit LEFT_WINS_TIE = 1'b1,
   localparam int IDX_W = (N_TOKENS > 1) ? $clog2(N_TOKENS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             l_sem_sel,
   input  logic [IDX_W-1:0] l_idx,
   input  logic             l_wr,
   input  logic             l_wdata,
   output logic             l_rdata,
   input  logic             r_sem_sel,
   input  logic [IDX_W-1:0] r_idx,
   input  logic             r_wr,
   input  logic             r_wdata,
   output logic             r_rdata
);
   if (N_TOKENS < 1 || N_TOKENS > 1024) begin : g_bad_count
      $error("sem_token_bank: N_TOKENS must lie in 1..1024");
   end

   logic [N_TOKENS-1:0] l_claim, l_drop, r_claim, r_drop;
   logic [N_TOKENS-1:0] l_held, r_held;

   sem_port_decode #(.N_TOKENS(N_TOKENS)) u_dec_l (
      .sel(l_sem_sel), .idx(l_idx), .wr(l_wr), .wdata(l_wdata),
      .claim(l_claim), .drop(l_drop));
   sem_port_decode #(.N_TOKENS(N_TOKENS)) u_dec_r (
      .sel(r_sem_sel), .idx(r_idx), .wr(r_wr), .wdata(r_wdata),
      .claim(r_claim), .drop(r_drop));

   for (genvar g = 0; g < N_TOKENS; g++) begin : g_tok
      sem_token_cell #(.LEFT_WINS_TIE(LEFT_WINS_TIE)) u_cell (
         .clk(clk), .rst_n(rst_n),
         .l_claim(l_claim[g]), .l_drop(l_drop[g]),
         .r_claim(r_claim[g]), .r_drop(r_drop[g]),
         .l_held(l_held[g]), .r_held(r_held[g]));
   end

   sem_read_mux #(.N_TOKENS(N_TOKENS)) u_rd_l (
      .sel(l_sem_sel), .idx(l_idx), .held(l_held), .rdata(l_rdata));
   sem_read_mux #(.N_TOKENS(N_TOKENS)) u_rd_r (
      .sel(r_sem_sel), .idx(r_idx), .held(r_held), .rdata(r_rdata));

   AST_UNSEL_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_sem_sel |-> l_rdata) and (!r_sem_sel |-> r_rdata)); // R10
   AST_NOT_BOTH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (l_sem_sel && r_sem_sel && l_idx == r_idx) |-> (l_rdata || r_rdata)); // R3
endmodule

// File: tb/sim_sem_token_bank.sv
`timescale 1ns/1ps
module sim_sem_token_bank;
   localparam int N = 8;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ls, lw, ld, rs, rw, rd;
   logic [2:0] li, ri;
   logic l_rdata, r_rdata;
   int checks = 0;
   int errors = 0;
   int m_own [N];   // 0 free, 1 left, 2 right
   int m_wait [N];

   always #2.5 clk = ~clk;

   sem_token_bank #(.N_TOKENS(N)) u0 (
      .clk(clk), .rst_n(rst_n),
      .l_sem_sel(ls), .l_idx(li), .l_wr(lw), .l_wdata(ld), .l_rdata(l_rdata),
      .r_sem_sel(rs), .r_idx(ri), .r_wr(rw), .r_wdata(rd), .r_rdata(r_rdata));

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic model_step();
      for (int t = 0; t < N; t++) begin
         bit lc, lr, rc, rr, lwt, rwt;
         lc = ls && lw && !ld && li == t;
         lr = ls && lw &&  ld && li == t;
         rc = rs && rw && !rd && ri == t;
         rr = rs && rw &&  rd && ri == t;
         lwt = (m_wait[t] != 0 && !lr) || lc;
         rwt = (m_wait[t] != 0 && !rr) || rc;
         if (m_own[t] == 0) begin
            if (lc) begin m_own[t] = 1; m_wait[t] = rc ? 1 : 0; end
            else if (rc) begin m_own[t] = 2; m_wait[t] = 0; end
         end else if (m_own[t] == 1) begin
            if (lr) begin m_own[t] = rwt ? 2 : 0; m_wait[t] = 0; end
            else m_wait[t] = rwt ? 1 : 0;
         end else begin
            if (rr) begin m_own[t] = lwt ? 1 : 0; m_wait[t] = 0; end
            else m_wait[t] = lwt ? 1 : 0;
         end
      end
   endtask

   task automatic cyc(input logic a_s, input int a_i, input logic a_w, input logic a_d,
                      input logic b_s, input int b_i, input logic b_w, input logic b_d);
      @(negedge clk);
      ls = a_s; li = 3'(a_i); lw = a_w; ld = a_d;
      rs = b_s; ri = 3'(b_i); rw = b_w; rd = b_d;
      @(posedge clk);
      model_step();
      @(negedge clk);
      lw = 1'b0; rw = 1'b0;
   endtask

   task automatic chk(input string tag, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %0b expected %0b", tag, got, exp);
      end
   endtask

   task automatic read_tok(input int t, input string tag);
      ls = 1'b1; rs = 1'b1; lw = 1'b0; rw = 1'b0;
      li = 3'(t); ri = 3'(t);
      #0.1;
      chk({tag, " left"},  l_rdata, m_own[t] == 1 ? 1'b0 : 1'b1);
      chk({tag, " right"}, r_rdata, m_own[t] == 2 ? 1'b0 : 1'b1);
   endtask

   task automatic read_all(input string tag);
      for (int t = 0; t < N; t++) read_tok(t, tag);
   endtask

   initial begin
      for (int t = 0; t < N; t++) begin m_own[t] = 0; m_wait[t] = 0; end
      ls = 0; rs = 0; lw = 0; rw = 0; ld = 1; rd = 1; li = 0; ri = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      read_all("R1 reset");

      cyc(1, 2, 1, 0, 0, 0, 0, 0);          read_tok(2, "R2 R3 claim");
      chk("R2 left holds", m_own[2] == 1, 1'b1);
      cyc(0, 0, 0, 0, 1, 2, 1, 0);          read_tok(2, "R4 wait");
      cyc(1, 2, 1, 1, 0, 0, 0, 0);          read_tok(2, "R5 handoff");
      chk("R5 right now holds", r_rdata, 1'b0);
      cyc(0, 0, 0, 0, 1, 2, 1, 1);          read_tok(2, "R6 free");

      cyc(1, 5, 1, 0, 1, 5, 1, 0);          read_tok(5, "R7 tie");
      chk("R7 left wins", l_rdata, 1'b0);
      cyc(1, 5, 1, 1, 0, 0, 0, 0);          read_tok(5, "R7 loser gets it");
      cyc(0, 0, 0, 0, 1, 5, 1, 1);

      cyc(1, 1, 1, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 1, 1, 1, 1);          read_tok(1, "R8 stray release");
      chk("R8 left still holds", l_rdata, 1'b0);
      cyc(1, 1, 1, 1, 0, 0, 0, 0);          read_tok(1, "R8 freed");
      chk("R8 right not granted", r_rdata, 1'b1);
      cyc(0, 0, 0, 0, 1, 0, 1, 1);          read_all("R8 free stray");

      cyc(1, 3, 1, 0, 1, 3, 1, 0);
      cyc(0, 0, 0, 0, 1, 3, 1, 1);
      cyc(1, 3, 1, 1, 0, 0, 0, 0);          read_tok(3, "R9 withdrawn");
      chk("R9 right not granted", r_rdata, 1'b1);

      cyc(0, 4, 1, 0, 0, 4, 1, 0);          read_tok(4, "R10 unselected write");
      ls = 0; rs = 0; li = 3'd4; ri = 3'd4; #0.1;
      chk("R10 left unselected read", l_rdata, 1'b1);
      chk("R10 right unselected read", r_rdata, 1'b1);
      cyc(1, 4, 1, 0, 0, 0, 0, 0);
      ls = 0; #0.1;
      chk("R10 holder unselected read", l_rdata, 1'b1);
      cyc(1, 4, 1, 1, 0, 0, 0, 0);

      cyc(1, 6, 1, 0, 1, 7, 1, 0);          read_all("R11 independent");
      chk("R11 left has 6", m_own[6] == 1 && m_own[7] == 2, 1'b1);

      for (int k = 0; k < 3000; k++) begin
         cyc(($urandom % 8) != 0, int'($urandom % 8), 1'($urandom), 1'($urandom),
             ($urandom % 8) != 0, int'($urandom % 8), 1'($urandom), 1'($urandom));
         read_all("R11 sweep");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule